// File: doc/BRIEF.md
# State-Masked Event Capture Unit

This block sits beside a timer and decides, cycle by cycle, which of thirteen raw event strobes count as real events. It also copies the timer's counter into capture registers when a qualified event selects them. Each event has a 16-bit state-membership mask. An event qualifies only when three things hold: its raw strobe is high, the mask bit indexed by the current state of its counter half is set, and that half is not halted. The counter, the state machine and the event generators are outside the block and reach it as inputs.

The unit runs in one of two modes. In unified mode the counter is one 32-bit value, and every event is judged against the low state variable and the low halt flag. In split mode the counter is two independent 16-bit halves. Each event then follows the half chosen by its own select bit, and each capture register loads its two halves separately. A byte-enabled register port holds the masks, the capture control words and the capture registers themselves.

Top module: `evcap_unit`

## Requirements
- R1: Synchronous reset clears every state mask, every capture control word, every capture register, `ev_qual` and `reg_rdata` to zero.
- R2: Event n qualifies when `ev_raw[n]` is high and bit s of its mask is 1, where s is the 4-bit state of its half. The qualified result appears on `ev_qual[n]` after the next rising edge.
- R3: An event whose mask is all zeros never qualifies, whatever the state.
- R4: In split mode (`split_mode`=1), `ev_hsel[n]`=1 makes event n use `state_hi` and `halt_hi`. Otherwise it uses `state_lo` and `halt_lo`.
- R5: While the halt flag of an event's half is 1, that event does not qualify.
- R6: In unified mode every event uses `state_lo` and `halt_lo`, and `ev_hsel` has no effect.
- R7: In unified mode, bit m (m<13) of capture control word c makes qualified event m load all 32 bits of capture c from `cnt_val`. Bits 31:16 of the control word have no effect.
- R8: In split mode, control bit m loads capture bits 15:0 from `cnt_val[15:0]`, and control bit 16+m loads capture bits 31:16 from `cnt_val[31:16]`.
- R9: Capture loads on the edge where the qualified event is present. Several coinciding selected events give one load of the current counter value.
- R10: Register map: address bits 5:4 select the region, 0 for masks, 1 for control words, 2 for captures. Address bits 3:0 select the index, 0 to 12. Writes honour `reg_be` per byte, so a 16-bit half write leaves the other half unchanged. Masks hold 16 bits and read back with bits 31:16 zero. Other addresses read zero and ignore writes. `reg_rdata` is registered and shows the contents from before the edge.
- R11: When a port write and a capture load hit the same capture half on the same edge, the capture load wins for that half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_mode | input | 1 | 1 = two 16-bit halves, 0 = one 32-bit counter |
| cnt_val | input | 32 | Current counter value |
| state_lo | input | 4 | State of the low (or unified) counter |
| state_hi | input | 4 | State of the high counter half |
| halt_lo | input | 1 | Low (or unified) counter halted |
| halt_hi | input | 1 | High counter half halted |
| ev_raw | input | 13 | Raw event strobes |
| ev_hsel | input | 13 | Per-event half select, 1 = high half |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_be | input | 4 | Byte enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ev_qual | output | 13 | Registered qualified event vector |
| cap_flat | output | 416 | Capture registers, capture c at bits 32c+31:32c |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it: `ev_qual`, the capture loads and the registered read data. A mask or control write takes effect for events presented on the following edge. The bench drives inputs 1 ns after a rising edge. At the next rising edge it advances its own model using the inputs held during that cycle and the register contents from before the edge. 1 ns later it compares all three outputs with that model, so every comparison falls one edge after its stimulus.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    RG_MASK = 2'd0,
    RG_CTRL = 2'd1,
    RG_CAP  = 2'd2,
    RG_NONE = 2'd3
  } evcap_region_e;
endpackage

// File: rtl/evcap_qualify.sv
module evcap_qualify #(
  parameter int N_EV = 13,
  parameter int ST_W = 4,
  localparam int N_ST = 1 << ST_W
) (
  input  logic                   split_mode,
  input  logic [N_EV-1:0]        ev_raw,
  input  logic [N_EV-1:0]        ev_hsel,
  input  logic [ST_W-1:0]        state_lo,
  input  logic [ST_W-1:0]        state_hi,
  input  logic                   halt_lo,
  input  logic                   halt_hi,
  input  logic [N_EV*N_ST-1:0]   mask_flat,
  output logic [N_EV-1:0]        qual
);
  // Per-event qualification; the half select only matters in split mode
  for (genvar e = 0; e < N_EV; e++) begin : g_ev
    logic            use_hi;
    logic [ST_W-1:0] cur_st;
    logic            cur_halt;
    logic [N_ST-1:0] msk;
    assign use_hi   = split_mode & ev_hsel[e];
    assign cur_st   = use_hi ? state_hi : state_lo;
    assign cur_halt = use_hi ? halt_hi : halt_lo;
    assign msk      = mask_flat[e*N_ST +: N_ST];
    assign qual[e]  = ev_raw[e] & ~cur_halt & msk[cur_st];
  end
endmodule

// File: rtl/evcap_regs.sv
module evcap_regs
  import evcap_pkg::*;
#(
  parameter int N_EV  = 13,
  parameter int N_CAP = 13,
  parameter int N_ST  = 16,
  parameter int AW    = 6,
  localparam int IW   = AW - 2,
  localparam int NB   = DATA_W / 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_we,
  input  logic [AW-1:0]           reg_addr,
  input  logic [NB-1:0]           reg_be,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [N_EV*N_ST-1:0]    mask_flat,
  output logic [N_CAP*DATA_W-1:0] ctrl_flat
);
  evcap_region_e rg;
  logic [IW-1:0] idx;
  assign rg  = evcap_region_e'(reg_addr[AW-1:AW-2]);
  assign idx = reg_addr[IW-1:0];

  for (genvar e = 0; e < N_EV; e++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_flat[e*N_ST +: N_ST] <= '0;
      end else if (reg_we && rg == RG_MASK && idx == IW'(e)) begin
        for (int b = 0; b < N_ST/8; b++)
          if (reg_be[b]) mask_flat[e*N_ST + b*8 +: 8] <= reg_wdata[b*8 +: 8];
      end
    end
  end

  for (genvar c = 0; c < N_CAP; c++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_flat[c*DATA_W +: DATA_W] <= '0;
      end else if (reg_we && rg == RG_CTRL && idx == IW'(c)) begin
        for (int b = 0; b < NB; b++)
          if (reg_be[b]) ctrl_flat[c*DATA_W + b*8 +: 8] <= reg_wdata[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/evcap_capture.sv
module evcap_capture #(
  parameter int N_EV  = 13,
  parameter int N_CAP = 13,
  parameter int CNT_W = 32,
  localparam int NB   = CNT_W / 8,
  localparam int HB   = NB / 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   split_mode,
  input  logic [N_EV-1:0]        qual,
  input  logic [N_CAP*N_EV-1:0]  sel_lo_flat,
  input  logic [N_CAP*N_EV-1:0]  sel_hi_flat,
  input  logic [CNT_W-1:0]       cnt_val,
  input  logic [N_CAP-1:0]       cap_we,
  input  logic [NB-1:0]          reg_be,
  input  logic [CNT_W-1:0]       reg_wdata,
  output logic [N_CAP*CNT_W-1:0] cap_flat
);
  for (genvar c = 0; c < N_CAP; c++) begin : g_cap
    logic ld_lo, ld_hi;
    assign ld_lo = |(sel_lo_flat[c*N_EV +: N_EV] & qual);
    assign ld_hi = split_mode ? |(sel_hi_flat[c*N_EV +: N_EV] & qual) : ld_lo;

    // Per byte: capture load beats a port write to the same half
    for (genvar b = 0; b < NB; b++) begin : g_byte
      logic ld;
      assign ld = (b < HB) ? ld_lo : ld_hi;
      always_ff @(posedge clk) begin
        if (rst)
          cap_flat[c*CNT_W + b*8 +: 8] <= '0;
        else if (ld)
          cap_flat[c*CNT_W + b*8 +: 8] <= cnt_val[b*8 +: 8];
        else if (cap_we[c] && reg_be[b])
          cap_flat[c*CNT_W + b*8 +: 8] <= reg_wdata[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/evcap_unit.sv
module evcap_unit
  import evcap_pkg::*;
#(
  parameter int N_EV  = 13,
  parameter int N_CAP = 13,
  parameter int ST_W  = 4,
  parameter int CNT_W = 32,
  parameter int AW    = 6,
  localparam int N_ST = 1 << ST_W,
  localparam int HALF = CNT_W / 2,
  localparam int IW   = AW - 2,
  localparam int NB   = DATA_W / 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   split_mode,
  input  logic [CNT_W-1:0]       cnt_val,
  input  logic [ST_W-1:0]        state_lo,
  input  logic [ST_W-1:0]        state_hi,
  input  logic                   halt_lo,
  input  logic                   halt_hi,
  input  logic [N_EV-1:0]        ev_raw,
  input  logic [N_EV-1:0]        ev_hsel,
  input  logic                   reg_we,
  input  logic [AW-1:0]          reg_addr,
  input  logic [NB-1:0]          reg_be,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  output logic [N_EV-1:0]        ev_qual,
  output logic [N_CAP*CNT_W-1:0] cap_flat
);
  logic [N_EV*N_ST-1:0]    mask_flat;
  logic [N_CAP*DATA_W-1:0] ctrl_flat;
  logic [N_CAP*N_EV-1:0]   sel_lo_flat, sel_hi_flat;
  logic [N_EV-1:0]         qual;
  logic [N_CAP-1:0]        cap_we;
  logic [DATA_W-1:0]       rd_next;
  evcap_region_e           rg;
  logic [IW-1:0]           idx;

  assign rg  = evcap_region_e'(reg_addr[AW-1:AW-2]);
  assign idx = reg_addr[IW-1:0];

  evcap_regs #(.N_EV(N_EV), .N_CAP(N_CAP), .N_ST(N_ST), .AW(AW)) u_regs (
    .clk, .rst, .reg_we, .reg_addr, .reg_be, .reg_wdata,
    .mask_flat, .ctrl_flat
  );

  evcap_qualify #(.N_EV(N_EV), .ST_W(ST_W)) u_qual (
    .split_mode, .ev_raw, .ev_hsel, .state_lo, .state_hi,
    .halt_lo, .halt_hi, .mask_flat, .qual
  );

  for (genvar c = 0; c < N_CAP; c++) begin : g_sel
    assign sel_lo_flat[c*N_EV +: N_EV] = ctrl_flat[c*DATA_W +: N_EV];
    assign sel_hi_flat[c*N_EV +: N_EV] = ctrl_flat[c*DATA_W + HALF +: N_EV];
    assign cap_we[c] = reg_we && rg == RG_CAP && idx == IW'(c);
  end

  evcap_capture #(.N_EV(N_EV), .N_CAP(N_CAP), .CNT_W(CNT_W)) u_cap (
    .clk, .rst, .split_mode, .qual, .sel_lo_flat, .sel_hi_flat,
    .cnt_val, .cap_we, .reg_be, .reg_wdata, .cap_flat
  );

  always_comb begin
    rd_next = '0;
    for (int e = 0; e < N_EV; e++)
      if (rg == RG_MASK && idx == IW'(e)) rd_next = DATA_W'(mask_flat[e*N_ST +: N_ST]);
    for (int c = 0; c < N_CAP; c++) begin
      if (rg == RG_CTRL && idx == IW'(c)) rd_next = ctrl_flat[c*DATA_W +: DATA_W];
      if (rg == RG_CAP && idx == IW'(c))  rd_next = DATA_W'(cap_flat[c*CNT_W +: CNT_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      ev_qual   <= '0;
    end else begin
      reg_rdata <= rd_next;
      ev_qual   <= qual;
    end
  end
endmodule

// File: rtl/evcap_sva.sv
module evcap_sva #(
  parameter int N_EV  = 13,
  parameter int N_CAP = 13,
  parameter int ST_W  = 4,
  parameter int CNT_W = 32,
  localparam int N_ST = 1 << ST_W,
  localparam int HALF = CNT_W / 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   split_mode,
  input logic                   halt_lo,
  input logic                   halt_hi,
  input logic                   reg_we,
  input logic [CNT_W-1:0]       cnt_val,
  input logic [N_EV-1:0]        ev_raw,
  input logic [N_EV-1:0]        ev_hsel,
  input logic [N_EV-1:0]        ev_qual,
  input logic [N_EV*N_ST-1:0]   mask_flat,
  input logic [N_CAP*CNT_W-1:0] cap_flat
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ev_qual == '0 && cap_flat == '0));

  for (genvar e = 0; e < N_EV; e++) begin : g_ev
    assert_needs_raw_R2: assert property (@(posedge clk) disable iff (rst)
      !ev_raw[e] |=> !ev_qual[e]);
    assert_zero_mask_R3: assert property (@(posedge clk) disable iff (rst)
      (mask_flat[e*N_ST +: N_ST] == '0) |=> !ev_qual[e]);
    // halt of the chosen half blocks the event (R4, R6 choose the half)
    assert_halt_blocks_R5: assert property (@(posedge clk) disable iff (rst)
      ((split_mode && ev_hsel[e]) ? halt_hi : halt_lo) |=> !ev_qual[e]);
  end

  for (genvar c = 0; c < N_CAP; c++) begin : g_cap
    assert_lo_source_R8: assert property (@(posedge clk) disable iff (rst)
      !reg_we |=> ($stable(cap_flat[c*CNT_W +: HALF]) ||
                   cap_flat[c*CNT_W +: HALF] == $past(cnt_val[HALF-1:0])));
    assert_hi_source_R8: assert property (@(posedge clk) disable iff (rst)
      !reg_we |=> ($stable(cap_flat[c*CNT_W + HALF +: HALF]) ||
                   cap_flat[c*CNT_W + HALF +: HALF] == $past(cnt_val[CNT_W-1:HALF])));
  end
endmodule

bind evcap_unit evcap_sva #(
  .N_EV(N_EV), .N_CAP(N_CAP), .ST_W(ST_W), .CNT_W(CNT_W)
) u_sva (
  .clk, .rst, .split_mode, .halt_lo, .halt_hi, .reg_we, .cnt_val,
  .ev_raw, .ev_hsel, .ev_qual, .mask_flat, .cap_flat
);

// File: tb/sim_evcap_unit.sv
`timescale 1ns/1ps
module sim_evcap_unit;
  logic        clk = 0;
  logic        rst = 1;
  logic        split_mode = 0;
  logic [31:0] cnt_val = 0;
  logic [3:0]  state_lo = 0, state_hi = 0;
  logic        halt_lo = 0, halt_hi = 0;
  logic [12:0] ev_raw = 0, ev_hsel = 0;
  logic        reg_we = 0;
  logic [5:0]  reg_addr = 0;
  logic [3:0]  reg_be = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [12:0] ev_qual;
  logic [415:0] cap_flat;

  evcap_unit u0 (.*);

  always #5 clk = ~clk;

  logic [15:0] m_mask [13];
  logic [31:0] m_ctrl [13];
  logic [31:0] m_cap  [13];
  logic [12:0] exp_q;
  logic [31:0] exp_rd;
  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  function automatic logic [12:0] model_qual();
    logic [12:0] q;
    for (int e = 0; e < 13; e++) begin
      bit hi = split_mode && ev_hsel[e];
      logic [3:0] st = hi ? state_hi : state_lo;
      bit h = hi ? halt_hi : halt_lo;
      q[e] = ev_raw[e] && !h && m_mask[e][st];
    end
    return q;
  endfunction

  function automatic logic [31:0] model_read();
    int i = int'(reg_addr[3:0]);
    if (i > 12) return 32'h0;
    case (reg_addr[5:4])
      2'd0: return {16'h0, m_mask[i]};
      2'd1: return m_ctrl[i];
      2'd2: return m_cap[i];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic step();
    int i;
    @(posedge clk);
    if (rst) begin
      for (int k = 0; k < 13; k++) begin m_mask[k] = 0; m_ctrl[k] = 0; m_cap[k] = 0; end
      exp_q = 0; exp_rd = 0;
    end else begin
      logic [12:0] q;
      exp_rd = model_read();
      q = model_qual();
      i = int'(reg_addr[3:0]);
      for (int c = 0; c < 13; c++) begin
        bit lo = |(m_ctrl[c][12:0] & q);
        bit hi = split_mode ? |(m_ctrl[c][28:16] & q) : lo;
        for (int b = 0; b < 4; b++) begin
          if ((b < 2) ? lo : hi) m_cap[c][b*8 +: 8] = cnt_val[b*8 +: 8];
          else if (reg_we && reg_addr[5:4] == 2'd2 && i == c && reg_be[b])
            m_cap[c][b*8 +: 8] = reg_wdata[b*8 +: 8];
        end
      end
      if (reg_we && i < 13) begin
        for (int b = 0; b < 4; b++) if (reg_be[b]) begin
          if (reg_addr[5:4] == 2'd0 && b < 2) m_mask[i][b*8 +: 8] = reg_wdata[b*8 +: 8];
          if (reg_addr[5:4] == 2'd1) m_ctrl[i][b*8 +: 8] = reg_wdata[b*8 +: 8];
        end
      end
      exp_q = q;
    end
    #1;
    check(ev_qual === exp_q, "ev_qual", 32'(ev_qual), 32'(exp_q));
    check(reg_rdata === exp_rd, "reg_rdata", reg_rdata, exp_rd);
    for (int c = 0; c < 13; c++)
      if (cap_flat[c*32 +: 32] !== m_cap[c])
        check(0, $sformatf("cap%0d", c), cap_flat[c*32 +: 32], m_cap[c]);
    check(1, "caps", 0, 0);
  endtask

  task automatic wr(logic [5:0] a, logic [3:0] be, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_be = be; reg_wdata = d;
    step();
    reg_we = 0; reg_be = 0;
  endtask

  task automatic rd(logic [5:0] a);
    reg_addr = a;
    step();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7351));
    cur_req = "R1";
    repeat (3) step();
    rst = 0;
    rd(6'h00); rd(6'h10); rd(6'h20);

    // R2 / R7: unified, state 0, mask 0x0001 fires and loads full 32 bits
    cur_req = "R2";
    wr(6'h00, 4'b0011, 32'h0000_0001);
    wr(6'h10, 4'b1111, 32'hFFFF_0001);
    cur_req = "R7";
    cnt_val = 32'hDEAD_BEEF; ev_raw = 13'h0001; step();
    ev_raw = 0; cnt_val = 32'h1234_5678; step();
    cur_req = "R2";
    state_lo = 4'd1; ev_raw = 13'h0001; step(); ev_raw = 0; step();

    // R3: zero mask never fires
    cur_req = "R3";
    state_lo = 0; ev_raw = 13'h0020; step(); ev_raw = 0; step();

    // R5: halt blocks
    cur_req = "R5";
    halt_lo = 1; ev_raw = 13'h0001; step(); ev_raw = 0; halt_lo = 0; step();

    // R4: split, event 1 follows high half
    cur_req = "R4";
    split_mode = 1;
    wr(6'h01, 4'b0011, 32'h0000_0008);
    wr(6'h11, 4'b1111, 32'h0002_0000);
    ev_hsel = 13'h0002; state_hi = 4'd3; state_lo = 4'd0; cnt_val = 32'hAAAA_5555;
    ev_raw = 13'h0002; step(); ev_raw = 0; step();
    cur_req = "R5";
    halt_hi = 1; ev_raw = 13'h0002; step(); halt_hi = 0; ev_raw = 0; step();

    // R6: unified ignores hsel, uses state_lo
    cur_req = "R6";
    split_mode = 0; state_lo = 4'd3; state_hi = 4'd0; halt_hi = 1;
    wr(6'h11, 4'b1111, 32'h0000_0002);
    ev_raw = 13'h0002; cnt_val = 32'h0BAD_F00D; step(); ev_raw = 0; halt_hi = 0; step();

    // R8: split halves of capture 2
    cur_req = "R8";
    split_mode = 1; state_lo = 0; state_hi = 0; ev_hsel = 0;
    wr(6'h02, 4'b0011, 32'h0000_0001);
    wr(6'h03, 4'b0011, 32'h0000_0001);
    wr(6'h12, 4'b1111, 32'h0008_0004);
    cnt_val = 32'h1111_2222; ev_raw = 13'h0004; step();
    cnt_val = 32'h3333_4444; ev_raw = 13'h0008; step();
    ev_raw = 0; rd(6'h22);

    // R9: coincident events, one load
    cur_req = "R9";
    wr(6'h12, 4'b1111, 32'h000C_000C);
    cnt_val = 32'h5A5A_A5A5; ev_raw = 13'h000C; step(); ev_raw = 0; rd(6'h22);

    // R10: half writes, readback, unmapped addresses
    cur_req = "R10";
    wr(6'h04, 4'b0001, 32'hFFFF_FFAB); rd(6'h04);
    wr(6'h14, 4'b1100, 32'hCAFE_0000); rd(6'h14);
    wr(6'h0F, 4'b1111, 32'hFFFF_FFFF); rd(6'h0F); rd(6'h30);

    // R11: capture beats port write on the same half
    cur_req = "R11";
    wr(6'h15, 4'b1111, 32'h0000_0004);
    cnt_val = 32'h7777_8888; ev_raw = 13'h0004;
    wr(6'h25, 4'b1111, 32'h1234_5678);
    ev_raw = 0; rd(6'h25);

    // random phase covering R2 R4 R5 R6 R7 R8 R10 R11
    cur_req = "R2-random";
    for (int n = 0; n < 4000; n++) begin
      cnt_val  = $urandom;
      state_lo = 4'($urandom); state_hi = 4'($urandom);
      halt_lo  = ($urandom % 8) == 0; halt_hi = ($urandom % 8) == 0;
      ev_raw   = 13'($urandom); ev_hsel = 13'($urandom);
      if (($urandom % 64) == 0) split_mode = ~split_mode;
      reg_we   = ($urandom % 3) == 0;
      reg_addr = 6'($urandom % 48);
      reg_be   = 4'($urandom);
      reg_wdata = $urandom;
      step();
    end
    reg_we = 0;

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule